// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a 64-bit integer ALU that can split its datapath at run time into independent lanes. A lane-size input picks eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes.

Within each lane the block can add or subtract, with a choice of three overflow behaviours:

- wrap-around;
- signed saturation;
- unsigned saturation.

It can also compare lanes for equality or for signed greater-than. A compare writes an all-ones or all-zeros mask into each lane, so a later masking step can select between two data words pixel by pixel. Three whole-word logical operations (AND, AND with the first operand inverted, and OR) complete that select-by-mask idiom.

A request is presented as an opcode, a lane size, a saturation mode and two operands, qualified by a valid strobe. The result appears in a register one clock later, together with a valid flag. A cycle without a request leaves the result register as it was.

Top module: `simd_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Lane i occupies bits [i*W+W-1 : i*W]. No carry or borrow crosses a lane boundary, so each result lane depends only on the same lane of `a` and `b`.
- R2: `op` 0 is add (a+b) and `op` 1 is subtract (a-b), applied lane by lane. With `sat_mode` 0 or 3, each lane result is taken modulo 2^W.
- R3: With `sat_mode` 1 on 8-bit or 16-bit lanes, add and subtract use signed saturation. A lane whose true signed result lies outside the two's-complement range is clamped to -2^(W-1) or to 2^(W-1)-1.
- R4: With `sat_mode` 2 on 8-bit or 16-bit lanes, add and subtract use unsigned saturation. A result above 2^W-1 is clamped to all ones, and a result below 0 is clamped to 0.
- R5: On 32-bit lanes, `sat_mode` 1 and 2 have no effect, and add and subtract wrap exactly as under R2.
- R6: `op` 2 (equal) sets a lane to all ones when the two operand lanes are equal, and to all zeros otherwise.
- R7: `op` 3 (greater-than) sets a lane to all ones when lane `a` is greater than lane `b`, both read as signed two's-complement values, and to all zeros otherwise.
- R8: `op` 4 gives a&b, `op` 5 gives (~a)&b, and `op` 6 gives a|b. These act on the whole 64-bit word, whatever `lane_sz` and `sat_mode` are.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. `result` loads only on a cycle with `in_valid` high, and otherwise holds its value.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock.
- R11: `op` 7 is unused and produces a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (R2, R6, R7, R8, R11) |
| lane_sz | input | 2 | Lane width select (R1) |
| sat_mode | input | 2 | 0/3 wrap, 1 signed saturate, 2 unsigned saturate |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after a request |
| result | output | 64 | Registered result |

## Verification
The datapath has only one register stage, so a fault in any lane's adder, clamp or compare shows on the matching slice of `result` in the very next cycle. A carry that leaks across a lane boundary corrupts the neighbouring lane at once, and the sweep is built to catch it: its operands place a different value in every byte. A fault in the load enable or the valid flag shows on the first idle cycle, as a changed `result` or a stray `out_valid`.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W = 64;
    localparam int N_SIZES = 3;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CEQ  = 3'd2,
        OP_CGT  = 3'd3,
        OP_AND  = 3'd4,
        OP_ANDN = 3'd5,
        OP_OR   = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LS_8   = 2'd0,
        LS_16  = 2'd1,
        LS_32  = 2'd2,
        LS_32X = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        SM_WRAP  = 2'd0,
        SM_SSAT  = 2'd1,
        SM_USAT  = 2'd2,
        SM_WRAPX = 2'd3
    } sat_mode_e;

    typedef struct packed {
        alu_op_e             op;
        lane_sz_e            lsz;
        sat_mode_e           sat;
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   b;
    } alu_req_t;

    // Index into the per-size result arrays; sizes 2 and 3 share the widest lane.
    function automatic int unsigned size_index(lane_sz_e lsz);
        case (lsz)
            LS_8:    return 0;
            LS_16:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
    import simd_pkg::*;
#(
    parameter int DW     = 64,
    parameter int LW     = 8,
    parameter bit SAT_OK = 1'b1
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  sat_mode_e     sat,
    output logic [DW-1:0] y
);
    localparam int NL = DW / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        logic [LW:0]   ext;
        logic          ovf_s;

        assign la = a[g*LW +: LW];
        assign lb = b[g*LW +: LW];

        always_comb begin
            if (sub) ext = {1'b0, la} - {1'b0, lb};
            else     ext = {1'b0, la} + {1'b0, lb};
            lr = ext[LW-1:0];
            if (sub) ovf_s = (la[LW-1] != lb[LW-1]) && (lr[LW-1] != la[LW-1]);
            else     ovf_s = (la[LW-1] == lb[LW-1]) && (lr[LW-1] != la[LW-1]);
            if (SAT_OK && (sat == SM_SSAT) && ovf_s)
                lr = la[LW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
            else if (SAT_OK && (sat == SM_USAT) && ext[LW])
                lr = sub ? {LW{1'b0}} : {LW{1'b1}};
        end

        assign y[g*LW +: LW] = lr;
    end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
    parameter int DW = 64,
    parameter int LW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] eq_mask,
    output logic [DW-1:0] gt_mask
);
    localparam int NL = DW / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] la, lb;
        assign la = a[g*LW +: LW];
        assign lb = b[g*LW +: LW];
        assign eq_mask[g*LW +: LW] = {LW{la == lb}};
        assign gt_mask[g*LW +: LW] = {LW{$signed(la) > $signed(lb)}};
    end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [1:0]    lane_sz,
    input  logic [1:0]    sat_mode,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_valid,
    output logic [DW-1:0] result
);
    localparam int BASE_W = 8;

    logic            is_sub;
    logic [DW-1:0]   arith_r [N_SIZES];
    logic [DW-1:0]   eq_r    [N_SIZES];
    logic [DW-1:0]   gt_r    [N_SIZES];
    logic [DW-1:0]   nxt;
    int unsigned     sidx;

    alu_op_e   op_e;
    lane_sz_e  lsz_e;
    sat_mode_e sat_e;

    assign op_e   = alu_op_e'(op);
    assign lsz_e  = lane_sz_e'(lane_sz);
    assign sat_e  = sat_mode_e'(sat_mode);
    assign is_sub = (op_e == OP_SUB);
    assign sidx   = size_index(lsz_e);

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        localparam int LW = BASE_W << k;

        simd_lane_arith #(
            .DW     (DW),
            .LW     (LW),
            .SAT_OK (LW < 32)
        ) u_arith (
            .a   (a),
            .b   (b),
            .sub (is_sub),
            .sat (sat_e),
            .y   (arith_r[k])
        );

        simd_lane_cmp #(
            .DW (DW),
            .LW (LW)
        ) u_cmp (
            .a       (a),
            .b       (b),
            .eq_mask (eq_r[k]),
            .gt_mask (gt_r[k])
        );
    end

    always_comb begin
        case (op_e)
            OP_ADD, OP_SUB: nxt = arith_r[sidx];
            OP_CEQ:         nxt = eq_r[sidx];
            OP_CGT:         nxt = gt_r[sidx];
            OP_AND:         nxt = a & b;
            OP_ANDN:        nxt = ~a & b;
            OP_OR:          nxt = a | b;
            default:        nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt;
        end
    end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [2:0]    op,
    input logic [DW-1:0] a,
    input logic [DW-1:0] b,
    input logic          out_valid,
    input logic [DW-1:0] result
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                    // R9
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                  // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));                             // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));                      // R10
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2 && a == b) |=> (result == '1));     // R6
    AST_GT_SELF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3 && a == b) |=> (result == '0));     // R7
    AST_OR_WORD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd6) |=> (result == ($past(a) | $past(b)))); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd7) |=> (result == '0));               // R11
endmodule

bind simd_alu simd_alu_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  lane_sz = '0;
    logic [1:0]  sat_mode = '0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        out_valid;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    simd_alu u_simd_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .sat_mode(sat_mode), .a(a), .b(b), .out_valid(out_valid), .result(result)
    );

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(int o, int lsz, int sm, logic [63:0] x, logic [63:0] y);
        int w;
        longint m, half;
        logic [63:0] res;
        w = (lsz == 0) ? 8 : (lsz == 1) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        res = '0;
        case (o)
            4: return x & y;
            5: return ~x & y;
            6: return x | y;
            7: return '0;
            default: ;
        endcase
        for (int i = 0; i < 64 / w; i++) begin
            longint ua, ub, sa, sb, r;
            ua = longint'(x >> (i * w)) & m;
            ub = longint'(y >> (i * w)) & m;
            sa = (ua >= half) ? ua - (m + 1) : ua;
            sb = (ub >= half) ? ub - (m + 1) : ub;
            r = 0;
            if (o == 0 || o == 1) begin
                if (sm == 1 && w < 32)
                    r = clampv((o == 0) ? sa + sb : sa - sb, -half, half - 1);
                else if (sm == 2 && w < 32)
                    r = clampv((o == 0) ? ua + ub : ua - ub, 0, m);
                else
                    r = (o == 0) ? ua + ub : ua - ub;
            end else if (o == 2) r = (ua == ub) ? m : 0;
            else r = (sa > sb) ? m : 0;
            res = res | (64'(r & m) << (i * w));
        end
        return res;
    endfunction

    function automatic string tag_of(int o, int lsz, int sm);
        if (o >= 4 && o <= 6) return "R8";
        if (o == 7) return "R11";
        if (o == 2) return "R6";
        if (o == 3) return "R7";
        if ((sm == 1 || sm == 2) && lsz >= 2) return "R5";
        if (sm == 1) return "R3";
        if (sm == 2) return "R4";
        return "R2";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, check one cycle later (R9 latency).
    task automatic send(int o, int lsz, int sm, logic [63:0] x, logic [63:0] y);
        op = 3'(o); lane_sz = 2'(lsz); sat_mode = 2'(sm); a = x; b = y; in_valid = 1'b1;
        @(negedge clk);
        chk(tag_of(o, lsz, sm), result, model(o, lsz, sm, x, y));
        chk("R9", 64'(out_valid), 64'd1);
    endtask

    task automatic all_modes(logic [63:0] x, logic [63:0] y);
        for (int o = 0; o < 8; o++)
            for (int l = 0; l < 4; l++)
                for (int s = 0; s < 4; s++)
                    if (o < 2 || s == 0) send(o, l, s, x, y);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        chk("R10", {63'd0, out_valid}, 64'd0);
        chk("R10", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: carry out of lane 0 must not reach lane 1
        send(0, 0, 0, 64'h00000000_000000FF, 64'h00000000_00000001);
        chk("R1", result, 64'h0);
        send(0, 1, 0, 64'h00000000_0000FFFF, 64'h00000000_00000001);
        chk("R1", result, 64'h0);
        send(1, 2, 0, 64'h00000001_00000000, 64'h00000000_00000001);
        chk("R1", result, 64'h00000001_FFFFFFFF);
        // R5: saturation ignored on 32-bit lanes
        send(0, 2, 1, 64'h7FFFFFFF_FFFFFFFF, 64'h00000001_00000001);
        chk("R5", result, 64'h80000000_00000000);
        send(0, 3, 2, 64'hFFFFFFFF_00000000, 64'h00000001_00000000);
        chk("R5", result, 64'h0);
        // R3 / R4 directed
        send(0, 0, 1, {8{8'h7F}}, {8{8'h01}});
        chk("R3", result, {8{8'h7F}});
        send(1, 1, 1, {4{16'h8000}}, {4{16'h0001}});
        chk("R3", result, {4{16'h8000}});
        send(1, 0, 2, {8{8'h01}}, {8{8'h02}});
        chk("R4", result, 64'h0);
        // R7 signed compare
        send(3, 0, 0, {8{8'h01}}, {8{8'hFF}});
        chk("R7", result, {8{8'hFF}});
        send(7, 0, 0, {8{8'h5A}}, {8{8'h33}});
        chk("R11", result, 64'h0);

        // Edge-value pairs across every mode
        all_modes({8{8'h7F}}, {8{8'h01}});
        all_modes({8{8'h80}}, {8{8'h01}});
        all_modes({8{8'hFF}}, {8{8'h01}});
        all_modes(64'h0, {8{8'hFF}});
        all_modes(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
        all_modes(64'h8000_7FFF_0000_FFFF, 64'h7FFF_8000_FFFF_0001);

        // Near-exhaustive sweep with different bytes in every lane
        for (int ia = 0; ia < 256; ia += 9) begin
            for (int ib = 0; ib < 256; ib += 11) begin
                logic [63:0] x, y;
                for (int k = 0; k < 8; k++) begin
                    x[k*8 +: 8] = 8'(ia + k * 37);
                    y[k*8 +: 8] = 8'(ib + k * 59);
                end
                for (int o = 0; o < 7; o++)
                    for (int l = 0; l < 3; l++)
                        for (int s = 0; s < 3; s++)
                            if (o < 2 || s == 0) send(o, l, s, x, y);
            end
        end

        // R9: idle cycle keeps result and drops valid
        send(0, 0, 0, {8{8'h11}}, {8{8'h22}});
        held = result;
        in_valid = 1'b0; a = '1; b = '1; op = 3'd6;
        @(negedge clk);
        chk("R9", {63'd0, out_valid}, 64'd0);
        chk("R9", result, held);
        // R10: reset mid-run
        send(6, 0, 0, 64'h1, 64'h2);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk("R10", result, 64'h0);
        chk("R10", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule